// File: doc/BRIEF.md
# Protected Register Write-Unlock Unit

This block holds four byte-wide control registers that runaway software must not be able to change by accident. Two of them select clocks for the processor, one sets the clock of the watchdog, and one selects a power-save mode. Each register sits on a simple single-cycle register bus that has an address, a write strobe, write data, a read strobe and read data. A write to one of these registers is accepted only when the bus write just before it went to a dedicated command address. The data written to the command address does not matter.

A protected write that is not unlocked in this way is discarded. It sets a sticky violation bit in a status register, which software clears by writing 1 to that bit. Reads are never restricted. A read-modify-write bit operation reaches the block as an ordinary bus write, so the same rule applies to it.

The block exports the current values of all protected registers. It also drives a power-save request output that follows the mode field of the power-save register one cycle late. That lag leaves an instruction slot after the accepting store.

Top module: `protRegGuard`

## Requirements
- R1: On synchronous active-high reset, every protected register becomes 0x00, the unlock is cleared, the violation bit is cleared and the power-save request is low.
- R2: A write to the command address (0x0) with any data, followed by a write to a protected address, stores the data. The new value appears on read data and on the exported vector after the clock edge that accepts it.
- R3: A write to a protected address whose previous bus write did not target the command address leaves the register unchanged. It also sets the violation bit, which is bit 0 of the status register at address 0x1.
- R4: Whatever its address, the next bus write uses up the unlock. Cycles without a write, and reads, do not use it up. A write to the status register or to an unmapped address after the command write therefore makes the next protected write fail.
- R5: A command write that follows another command write keeps the unlock set.
- R6: The violation bit stays set until a write to the status address has data bit 0 equal to 1. A status write with data bit 0 equal to 0 leaves it set. Status writes need no unlock.
- R7: Read data is zero while the read strobe is low, and also when the command address or an unmapped address is read. Protected registers can be read at any time without an unlock.
- R8: The power-save mode is held in bits [1:0] of the register at address 0x7, where 01 selects idle and 10 selects stop. The request output goes high one cycle after the register takes either value. It goes low one cycle after the register takes 00 or 11.
- R9: A read-modify-write, meaning a read-back value written again with one bit changed, succeeds only after a command write. Without one, the register keeps its old value.
- R10: The protected registers sit at addresses 0x4 to 0x7 and can be written independently. The exported vector carries the register at 0x4 in bits [7:0], and each higher address occupies the next byte up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Bus address |
| wrEn | input | 1 | Write strobe |
| wrData | input | DATA_W | Write data |
| rdEn | input | 1 | Read strobe |
| rdData | output | DATA_W | Read data (combinational) |
| protRegs | output | NUM_PROT*DATA_W | All protected register values, lowest address in the low byte |
| pwrReq | output | 1 | Power-save request |

## Verification
The bench uses the default parameters: a 4-bit address, 8-bit data and four protected registers based at 0x4, with the command at 0x0 and the status at 0x1. A 4-bit address leaves 0x2, 0x3 and 0x8 to 0xF unmapped. The bench can therefore write to an unmapped address between an unlock and a protected write, and read back zero from those locations. Because the power-save register is the top one of the four, the one-cycle lag of the request can be observed, as can the way a rejected write leaves that request untouched.

// File: rtl/protRegGuardPkg.sv
package protRegGuardPkg;
  // Index width of the register-select strobe; covers up to 16 protected registers.
  localparam int SEL_W = 4;

  typedef struct packed {
    logic             load;  // accepted write to a protected register
    logic [SEL_W-1:0] sel;   // which protected register
  } guardStrobe_t;
endpackage

// File: rtl/protRegGuardCtrl.sv
module protRegGuardCtrl
  import protRegGuardPkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int NUM_PROT  = 4,
  parameter int CMD_ADDR  = 0,
  parameter int STAT_ADDR = 1,
  parameter int PROT_BASE = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              clrBit,
  output guardStrobe_t      strb,
  output logic              violFlag
);
  logic armed;
  logic isCmd, isStat, isProt;
  logic [SEL_W-1:0] protSel;

  assign isCmd  = (addr == ADDR_W'(CMD_ADDR));
  assign isStat = (addr == ADDR_W'(STAT_ADDR));

  always_comb begin
    isProt  = 1'b0;
    protSel = '0;
    for (int i = 0; i < NUM_PROT; i++) begin
      if (addr == ADDR_W'(PROT_BASE + i)) begin
        isProt  = 1'b1;
        protSel = SEL_W'(i);
      end
    end
  end

  assign strb.load = wrEn && isProt && armed;
  assign strb.sel  = protSel;

  // Any write consumes the unlock; a command write (re)arms it.
  always_ff @(posedge clk) begin
    if (rst)       armed <= 1'b0;
    else if (wrEn) armed <= isCmd;
  end

  always_ff @(posedge clk) begin
    if (rst)                              violFlag <= 1'b0;
    else if (wrEn && isProt && !armed)    violFlag <= 1'b1;
    else if (wrEn && isStat && clrBit)    violFlag <= 1'b0;
  end

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (!armed && !violFlag)); // R1
  AST_REJECT_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (wrEn && isProt && !armed) |=> violFlag); // R3
  AST_ARM_CONSUMED: assert property (@(posedge clk) disable iff (rst)
    (wrEn && !isCmd) |=> !armed); // R4
  AST_CMD_ARMS: assert property (@(posedge clk) disable iff (rst)
    (wrEn && isCmd) |=> armed); // R5
  AST_VIOL_STICKY: assert property (@(posedge clk) disable iff (rst)
    (violFlag && !(wrEn && isStat && clrBit)) |=> violFlag); // R6
endmodule

// File: rtl/protRegGuardData.sv
module protRegGuardData
  import protRegGuardPkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 8,
  parameter int NUM_PROT  = 4,
  parameter int STAT_ADDR = 1,
  parameter int PROT_BASE = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [DATA_W-1:0]          wrData,
  input  logic                       rdEn,
  input  guardStrobe_t               strb,
  input  logic                       violFlag,
  output logic [DATA_W-1:0]          rdData,
  output logic [NUM_PROT*DATA_W-1:0] protRegs,
  output logic                       pwrReq
);
  localparam int PS_IDX = NUM_PROT - 1;

  logic [DATA_W-1:0] protQ [NUM_PROT];
  logic              modeActive;

  for (genvar g = 0; g < NUM_PROT; g++) begin : gReg
    always_ff @(posedge clk) begin
      if (rst)                                        protQ[g] <= '0;
      else if (strb.load && strb.sel == SEL_W'(g))    protQ[g] <= wrData;
    end
    assign protRegs[g*DATA_W +: DATA_W] = protQ[g];
  end

  // 01 = idle, 10 = stop
  assign modeActive = (protQ[PS_IDX][1:0] == 2'b01) || (protQ[PS_IDX][1:0] == 2'b10);

  always_ff @(posedge clk) begin
    if (rst) pwrReq <= 1'b0;
    else     pwrReq <= modeActive;
  end

  always_comb begin
    rdData = '0;
    if (rdEn) begin
      if (addr == ADDR_W'(STAT_ADDR)) rdData = {{(DATA_W-1){1'b0}}, violFlag};
      for (int i = 0; i < NUM_PROT; i++) begin
        if (addr == ADDR_W'(PROT_BASE + i)) rdData = protQ[i];
      end
    end
  end

  AST_REG_HOLD: assert property (@(posedge clk) disable iff (rst)
    !strb.load |=> $stable(protRegs)); // R3
  AST_PWR_LAG: assert property (@(posedge clk) disable iff (rst)
    modeActive |=> pwrReq); // R8
  AST_PWR_DROP: assert property (@(posedge clk) disable iff (rst)
    !modeActive |=> !pwrReq); // R8
endmodule

// File: rtl/protRegGuard.sv
module protRegGuard
  import protRegGuardPkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 8,
  parameter int NUM_PROT  = 4,
  parameter int CMD_ADDR  = 0,
  parameter int STAT_ADDR = 1,
  parameter int PROT_BASE = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [ADDR_W-1:0]          addr,
  input  logic                       wrEn,
  input  logic [DATA_W-1:0]          wrData,
  input  logic                       rdEn,
  output logic [DATA_W-1:0]          rdData,
  output logic [NUM_PROT*DATA_W-1:0] protRegs,
  output logic                       pwrReq
);
  guardStrobe_t strb;
  logic         violFlag;

  protRegGuardCtrl #(
    .ADDR_W(ADDR_W), .NUM_PROT(NUM_PROT), .CMD_ADDR(CMD_ADDR),
    .STAT_ADDR(STAT_ADDR), .PROT_BASE(PROT_BASE)
  ) uCtrl (
    .clk(clk), .rst(rst), .addr(addr), .wrEn(wrEn), .clrBit(wrData[0]),
    .strb(strb), .violFlag(violFlag)
  );

  protRegGuardData #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_PROT(NUM_PROT),
    .STAT_ADDR(STAT_ADDR), .PROT_BASE(PROT_BASE)
  ) uData (
    .clk(clk), .rst(rst), .addr(addr), .wrData(wrData), .rdEn(rdEn),
    .strb(strb), .violFlag(violFlag), .rdData(rdData),
    .protRegs(protRegs), .pwrReq(pwrReq)
  );
endmodule

// File: tb/protRegGuard_test.sv
module protRegGuard_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  addr = '0;
  logic        wrEn = 1'b0;
  logic [7:0]  wrData = '0;
  logic        rdEn = 1'b0;
  logic [7:0]  rdData;
  logic [31:0] protRegs;
  logic        pwrReq;

  int nVec = 0;
  int nBad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  protRegGuard uut (
    .clk(clk), .rst(rst), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .rdEn(rdEn), .rdData(rdData), .protRegs(protRegs), .pwrReq(pwrReq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic busRead(input logic [3:0] a, output logic [7:0] d);
    addr = a; rdEn = 1'b1;
    #1 d = rdData;
    rdEn = 1'b0;
  endtask

  // {req[3:0], op[1:0] (0 write, 1 read-check), addr[3:0], data/expected[7:0]}
  localparam logic [17:0] VEC [32] = '{
    {4'd1, 2'd1, 4'h4, 8'h00},  // R1 reset value
    {4'd3, 2'd0, 4'h4, 8'hA5},  // R3 write without unlock
    {4'd3, 2'd1, 4'h4, 8'h00},
    {4'd3, 2'd1, 4'h1, 8'h01},
    {4'd6, 2'd0, 4'h1, 8'h01},  // R6 clear
    {4'd6, 2'd1, 4'h1, 8'h00},
    {4'd2, 2'd0, 4'h0, 8'hFF},  // R2 unlock then write
    {4'd2, 2'd0, 4'h4, 8'hA5},
    {4'd2, 2'd1, 4'h4, 8'hA5},
    {4'd5, 2'd0, 4'h0, 8'h00},  // R5 double command
    {4'd5, 2'd0, 4'h0, 8'h13},
    {4'd5, 2'd0, 4'h5, 8'h3C},
    {4'd5, 2'd1, 4'h5, 8'h3C},
    {4'd4, 2'd0, 4'h0, 8'h77},  // R4 unmapped write consumes
    {4'd4, 2'd0, 4'h9, 8'h11},
    {4'd4, 2'd0, 4'h6, 8'h55},
    {4'd4, 2'd1, 4'h6, 8'h00},
    {4'd4, 2'd1, 4'h1, 8'h01},
    {4'd6, 2'd0, 4'h1, 8'h00},  // R6 writing 0 keeps flag
    {4'd6, 2'd1, 4'h1, 8'h01},
    {4'd4, 2'd0, 4'h0, 8'h00},  // R4 status write consumes
    {4'd4, 2'd0, 4'h1, 8'h01},
    {4'd4, 2'd0, 4'h6, 8'h55},
    {4'd4, 2'd1, 4'h6, 8'h00},
    {4'd4, 2'd1, 4'h1, 8'h01},
    {4'd7, 2'd1, 4'h9, 8'h00},  // R7 unmapped read
    {4'd7, 2'd1, 4'h0, 8'h00},  // R7 command read
    {4'd9, 2'd0, 4'h0, 8'h00},  // R9 unlocked bit clear
    {4'd9, 2'd0, 4'h4, 8'hA4},
    {4'd9, 2'd1, 4'h4, 8'hA4},
    {4'd9, 2'd0, 4'h4, 8'hA5},  // R9 locked bit set rejected
    {4'd9, 2'd1, 4'h4, 8'hA4}
  };

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nVec++; nBad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 protRegs", protRegs, 32'h0);
    check("R1 pwrReq", {31'b0, pwrReq}, 32'h0);
    busRead(4'h1, rd);
    check("R1 status", {24'b0, rd}, 32'h0);

    for (int i = 0; i < 32; i++) begin
      if (VEC[i][13:12] == 2'd0) busWrite(VEC[i][11:8], VEC[i][7:0]);
      else begin
        busRead(VEC[i][11:8], rd);
        check($sformatf("R%0d vec%0d", VEC[i][17:14], i), {24'b0, rd}, {24'b0, VEC[i][7:0]});
      end
    end

    // R10 exported vector layout
    check("R10 protRegs", protRegs, 32'h00003CA4);
    busWrite(4'h0, 8'h00);
    busWrite(4'h7, 8'h80);
    check("R10 top byte", protRegs, 32'h80003CA4);

    // R7 read strobe low gives zero
    addr = 4'h4; rdEn = 1'b0;
    #1 check("R7 rdEn low", {24'b0, rdData}, 32'h0);

    // R4 idle cycles keep the unlock
    busWrite(4'h0, 8'h00);
    repeat (3) @(negedge clk);
    busWrite(4'h6, 8'h5A);
    busRead(4'h6, rd);
    check("R4 idle keeps unlock", {24'b0, rd}, 32'h5A);

    // R8 power-save request timing
    busWrite(4'h0, 8'h00);
    busWrite(4'h7, 8'h02);
    check("R8 stop lag", {31'b0, pwrReq}, 32'h0);
    @(negedge clk);
    check("R8 stop high", {31'b0, pwrReq}, 32'h1);
    busWrite(4'h0, 8'h00);
    busWrite(4'h7, 8'h01);
    @(negedge clk);
    check("R8 idle high", {31'b0, pwrReq}, 32'h1);
    busWrite(4'h0, 8'h00);
    busWrite(4'h7, 8'h03);
    check("R8 drop lag", {31'b0, pwrReq}, 32'h1);
    @(negedge clk);
    check("R8 drop low", {31'b0, pwrReq}, 32'h0);
    busWrite(4'h7, 8'h02);
    @(negedge clk);
    check("R8 rejected write", {31'b0, pwrReq}, 32'h0);

    // R1 reset mid-run clears unlock and registers
    busWrite(4'h0, 8'h00);
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    check("R1 regs after reset", protRegs, 32'h0);
    check("R1 pwrReq after reset", {31'b0, pwrReq}, 32'h0);
    busRead(4'h1, rd);
    check("R1 flag after reset", {24'b0, rd}, 32'h0);
    busWrite(4'h5, 8'h11);
    busRead(4'h5, rd);
    check("R1 unlock cleared", {24'b0, rd}, 32'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule